// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits between the two independent access ports of a shared memory and watches each port's word address and enable. When both ports are enabled on the same word, it records a collision, picks one port as the owner of that word and pulls the active-low busy line of the other port low. The owner is the port that was already on the word. The port that arrived later loses. If both arrive in the same cycle, the left port wins. Once a port owns the word, it keeps it for as long as the collision lasts. Ownership ends when the addresses differ or either port drops its enable.

A mode input lets several arbiters be combined to build a wider word. In master mode the block makes the decision and drives both busy outputs. In slave mode it makes no decision of its own and leaves its busy outputs high. It then takes busy from the external busy inputs, normally wired from a master arbiter, and uses them only to block writes. The block never blocks a read. The only thing it blocks is a port's write request, and only while that port's effective busy is low.

Top module: `dp_contention_arb`

## Requirements
- R1: When the two enabled port addresses differ, both busy outputs are high (inactive).
- R2: In master mode, if the left port was already enabled on a word in the previous cycle and the right port newly arrives on the same word, the right busy output goes low and the left stays high in that same cycle.
- R3: In master mode, if the right port was already on the word and the left port newly arrives, the left busy output goes low and the right stays high.
- R4: In master mode, when both ports begin a matching access in the same cycle, the left port is granted and the right busy output goes low.
- R5: While the match persists, the port that was granted keeps the grant, whatever the other port does, and at most one busy output is ever low.
- R6: When the addresses stop matching, both busy outputs return high in that cycle. The next match is decided afresh.
- R7: In master mode, the write request of the port whose busy is low is not passed to its write-enable output. The granted port's write request passes unchanged.
- R8: With the mode input low (slave), both busy outputs stay high. A low busy input blocks that port's write-enable output.
- R9: With the mode input low and a port's busy input high, that port's write request passes unchanged, even while the addresses collide.
- R10: A port whose enable is low never takes part in a match. Both busy outputs stay high and the other port's write passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | 1 = master (decides and drives busy), 0 = slave (busy taken from inputs) |
| l_en | input | 1 | Left port enable, active high |
| l_addr | input | AW | Left port word address |
| l_wr | input | 1 | Left port write request |
| r_en | input | 1 | Right port enable, active high |
| r_addr | input | AW | Right port word address |
| r_wr | input | 1 | Right port write request |
| l_busy_in_n | input | 1 | Left busy from a master arbiter, used in slave mode, active low |
| r_busy_in_n | input | 1 | Right busy from a master arbiter, used in slave mode, active low |
| l_busy_out_n | output | 1 | Left busy, active low, driven in master mode |
| r_busy_out_n | output | 1 | Right busy, active low, driven in master mode |
| l_wr_ok | output | 1 | Left write enable after gating |
| r_wr_ok | output | 1 | Right write enable after gating |

## Verification
The arbitration is tried with several arrival orders on a shared word:
- left first, which separates the left-wins case from the right-wins case;
- right first, which does the same in the other direction;
- both arriving together, which exposes the tie rule;
- a match that continues for several cycles, which shows whether the grant is held or re-decided each cycle;
- a mismatch followed by a fresh match in the opposite order, which shows that the grant is released and decided again.

A collision with one port disabled shows that the enable takes part in the address compare. In slave mode, colliding traffic is run with each busy input set high and then low. This shows that the block makes no decision of its own and that its busy inputs block only writes.

// File: rtl/dp_contention_arb.sv
module dp_contention_arb #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_sel,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          l_wr,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  input  logic          r_wr,
  input  logic          l_busy_in_n,
  input  logic          r_busy_in_n,
  output logic          l_busy_out_n,
  output logic          r_busy_out_n,
  output logic          l_wr_ok,
  output logic          r_wr_ok
);

  logic          l_en_q, r_en_q;
  logic [AW-1:0] l_addr_q, r_addr_q;
  logic          l_own_q, r_own_q;
  logic          hit, l_fresh, r_fresh, held, right_takes;
  logic          l_owns, r_owns;
  logic          l_gate_n, r_gate_n;

  assign hit         = l_en && r_en && (l_addr == r_addr);
  assign l_fresh     = !(l_en_q && (l_addr_q == l_addr));
  assign r_fresh     = !(r_en_q && (r_addr_q == r_addr));
  assign held        = l_own_q || r_own_q;
  assign right_takes = l_fresh && !r_fresh;

  assign l_owns = master_sel && hit && (held ? l_own_q : !right_takes);
  assign r_owns = master_sel && hit && (held ? r_own_q : right_takes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      l_own_q  <= 1'b0;
      r_own_q  <= 1'b0;
    end else begin
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      l_own_q  <= l_owns;
      r_own_q  <= r_owns;
    end
  end

  assign l_busy_out_n = !r_owns;
  assign r_busy_out_n = !l_owns;

  assign l_gate_n = master_sel ? l_busy_out_n : l_busy_in_n;
  assign r_gate_n = master_sel ? r_busy_out_n : r_busy_in_n;

  assign l_wr_ok = l_wr && l_gate_n;
  assign r_wr_ok = r_wr && r_gate_n;

endmodule

module dp_contention_arb_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          master_sel,
  input logic          l_en,
  input logic [AW-1:0] l_addr,
  input logic          l_wr,
  input logic          r_en,
  input logic [AW-1:0] r_addr,
  input logic          r_wr,
  input logic          l_busy_in_n,
  input logic          r_busy_in_n,
  input logic          l_busy_out_n,
  input logic          r_busy_out_n,
  input logic          l_wr_ok,
  input logic          r_wr_ok
);

  logic same_word, l_eff_n, r_eff_n;
  assign same_word = l_en && r_en && (l_addr == r_addr);
  assign l_eff_n   = master_sel ? l_busy_out_n : l_busy_in_n;
  assign r_eff_n   = master_sel ? r_busy_out_n : r_busy_in_n;

  AST_IDLE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !same_word |-> (l_busy_out_n && r_busy_out_n)); // R1
  AST_COLLIDE_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && same_word) |-> ($countones({~l_busy_out_n, ~r_busy_out_n}) == 1)); // R4
  AST_RIGHT_LOSS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && !r_busy_out_n) |=> (!(master_sel && same_word) || !r_busy_out_n)); // R5
  AST_LEFT_LOSS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (master_sel && !l_busy_out_n) |=> (!(master_sel && same_word) || !l_busy_out_n)); // R5
  AST_LOSER_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_eff_n |-> !l_wr_ok) and (!r_eff_n |-> !r_wr_ok)); // R7
  AST_SLAVE_BUSY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> (l_busy_out_n && r_busy_out_n)); // R8
  AST_FREE_WRITE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (l_eff_n |-> (l_wr_ok == l_wr)) and (r_eff_n |-> (r_wr_ok == r_wr))); // R9
  AST_DISABLED_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_en || !r_en) |-> (l_busy_out_n && r_busy_out_n)); // R10

endmodule

bind dp_contention_arb dp_contention_arb_chk #(.AW(AW)) chk_i (.*);

// File: tb/dp_contention_arb_tb.sv
`timescale 1ns/1ps
module dp_contention_arb_tb_top;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          master_sel = 1'b1;
  logic          l_en = 1'b0, r_en = 1'b0, l_wr = 1'b0, r_wr = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic          l_busy_out_n, r_busy_out_n, l_wr_ok, r_wr_ok;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dp_contention_arb #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
    .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
    .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_out_n(l_busy_out_n), .r_busy_out_n(r_busy_out_n),
    .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok));

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put(input logic el, input int al, input logic wl,
                     input logic er, input int ar, input logic wr);
    l_en = el; l_addr = AW'(al); l_wr = wl;
    r_en = er; r_addr = AW'(ar); r_wr = wr;
    #1;
  endtask

  task automatic chk_busy(input string tag, input logic exp_l, input logic exp_r);
    checks++;
    if (l_busy_out_n !== exp_l || r_busy_out_n !== exp_r) begin
      errors++;
      $display("FAIL %s busy l/r actual %b%b expected %b%b", tag,
               l_busy_out_n, r_busy_out_n, exp_l, exp_r);
    end
  endtask

  task automatic chk_wr(input string tag, input logic exp_l, input logic exp_r);
    checks++;
    if (l_wr_ok !== exp_l || r_wr_ok !== exp_r) begin
      errors++;
      $display("FAIL %s wr_ok l/r actual %b%b expected %b%b", tag,
               l_wr_ok, r_wr_ok, exp_l, exp_r);
    end
  endtask

  task automatic idle();
    put(0, 0, 0, 0, 0, 0);
    tick();
  endtask

  task automatic t_reset();
    put(0, 0, 0, 0, 0, 0);
    chk_busy("R1 reset", 1, 1);
    put(1, 2, 0, 1, 6, 0);
    chk_busy("R1 differing addresses", 1, 1);
    tick();
  endtask

  task automatic t_left_first();
    idle();
    put(1, 5, 0, 0, 5, 0);
    tick();
    put(1, 5, 1, 1, 5, 1);
    chk_busy("R2 left first", 1, 0);
    chk_wr("R7 right write blocked", 1, 0);
    tick();
  endtask

  task automatic t_right_first();
    idle();
    put(0, 9, 0, 1, 9, 0);
    tick();
    put(1, 9, 1, 1, 9, 1);
    chk_busy("R3 right first", 0, 1);
    chk_wr("R7 left write blocked", 0, 1);
    tick();
  endtask

  task automatic t_same_cycle_and_hold();
    idle();
    put(1, 3, 0, 1, 3, 1);
    chk_busy("R4 tie goes left", 1, 0);
    tick();
    for (int i = 0; i < 3; i++) begin
      put(1, 3, i[0], 1, 3, !i[0]);
      chk_busy("R5 grant held", 1, 0);
      tick();
    end
  endtask

  task automatic t_release();
    put(1, 3, 0, 1, 4, 1);
    chk_busy("R6 mismatch releases", 1, 1);
    chk_wr("R6 write passes after release", 0, 1);
    tick();
    put(1, 3, 0, 1, 3, 0);
    chk_busy("R6 right returns late", 1, 0);
    tick();
    put(1, 4, 0, 1, 3, 0);
    chk_busy("R6 mismatch again", 1, 1);
    tick();
    put(1, 3, 0, 1, 3, 0);
    chk_busy("R6 left returns late", 0, 1);
    tick();
  endtask

  task automatic t_disabled();
    idle();
    put(0, 8, 1, 1, 8, 1);
    chk_busy("R10 left disabled", 1, 1);
    chk_wr("R10 right write passes", 1, 1);
    tick();
    put(1, 8, 1, 0, 8, 1);
    chk_busy("R10 right disabled", 1, 1);
    tick();
  endtask

  task automatic t_slave();
    idle();
    master_sel = 1'b0;
    l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
    put(1, 7, 1, 1, 7, 1);
    chk_busy("R8 slave busy outputs high", 1, 1);
    chk_wr("R9 slave writes pass", 1, 1);
    tick();
    l_busy_in_n = 1'b0;
    put(1, 7, 1, 1, 7, 1);
    chk_wr("R8 slave left inhibited", 0, 1);
    tick();
    l_busy_in_n = 1'b1; r_busy_in_n = 1'b0;
    put(1, 7, 1, 1, 7, 1);
    chk_wr("R8 slave right inhibited", 1, 0);
    chk_busy("R8 slave still not driving", 1, 1);
    tick();
    r_busy_in_n = 1'b1;
    master_sel = 1'b1;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_left_first();
    t_right_first();
    t_same_cycle_and_hold();
    t_release();
    t_disabled();
    t_slave();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule